// File: doc/BRIEF.md
# Dual-Clock Frequency Comparator

The comparator decides whether a test clock runs at the expected rate relative to a reference clock. Two down-counters race each other. One runs on the reference clock and the other on the test clock. When the reference counter runs out, a second reference-domain counter opens a tolerance window. The measurement passes only if the test counter runs out while that window is open. If the test counter runs out before the window opens, or the window closes first, the measurement fails.

Software drives the block through a small word-addressed register port in the reference domain. It loads the three seed values, writes a control word, and then polls the status word. Status reads zero while a measurement is running and becomes nonzero when the measurement ends. Control fields are 4-bit codes and not single bits, so a corrupted write is unlikely to switch the block on. The test-source select field is only accepted together with a matching code in the same write.

The test-counter expiry crosses into the reference domain through a two-flop synchronizer. The comparison itself is made entirely in the reference domain. Arming the test counter uses a four-phase level handshake, so back-to-back measurements in continuous mode never overlap.

Top module: `fcmp_top`

## Requirements
- R1: After reset, the control word (address 0), the status word (address 1) and the source-select word (address 5) read as zero, and `tst_src_sel` is zero.
- R2: A measurement starts only when control bits 3:0 hold 0xA. Any other code, including 0x5 and 0x3, keeps the block idle, and the status stays zero.
- R3: With control bits 11:8 at 0xA (single-shot), a test count that ends inside the window sets status bit 1 (done). The block then stops, and status keeps that value while the block stays enabled.
- R4: A test count that ends before the window opens sets status bit 0 (error) and stops the block.
- R5: A window that closes before the test count ends sets status bit 0 (error) and stops the block.
- R6: Writing to address 1 clears each status bit whose write-data bit is 1, and leaves the others unchanged.
- R7: Status reads zero while a measurement is in progress.
- R8: Reference, window and test seeds are written at addresses 2, 3 and 4 in the low counter-width bits, and read back unchanged.
- R9: A write to address 5 updates `tst_src_sel` from data bits 3:0 only when data bits 15:12 are 0xA. Otherwise the select value is unchanged.
- R10: With control bits 11:8 not 0xA (continuous), passing measurements reload all seeds and repeat with status left at zero. A failing measurement sets error and stops.
- R11: Taking control bits 3:0 away from 0xA during a measurement aborts it, and no status bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; register port and comparison domain |
| ref_rst_n | input | 1 | Active-low reset, reference domain |
| tst_clk | input | 1 | Clock under test |
| tst_rst_n | input | 1 | Active-low reset, test domain |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (3) | Word address |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data for `reg_addr`, combinational |
| tst_src_sel | output | 4 | Accepted test-clock source select |

## Verification
A wrong window state would show up at the status word. A pass would read as error, or an early expiry as done, and this would appear within a few reference cycles of the test counter running out. A broken arm/expiry handshake shows up differently: either status never leaves zero, or a continuous run stops with an error. That can be seen within one measurement length. Decode faults in the code fields show up the same way, as a measurement that starts when it should stay idle, or the reverse. A faulty select-field decode shows up on `tst_src_sel` one cycle after the write.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam logic [3:0] KEY_ON  = 4'hA;
  localparam logic [3:0] KEY_OFF = 4'h5;

  localparam int unsigned A_CTRL  = 0;
  localparam int unsigned A_STAT  = 1;
  localparam int unsigned A_SREF  = 2;
  localparam int unsigned A_SWIN  = 3;
  localparam int unsigned A_STST  = 4;
  localparam int unsigned A_SRC   = 5;

  typedef enum logic [2:0] {
    MS_IDLE, MS_REF, MS_WIN, MS_RELOAD, MS_HALT
  } meas_state_t;

  // only the exact "on" code counts; every other value is off
  function automatic logic key_on(input logic [3:0] k);
    return k == KEY_ON;
  endfunction
endpackage

// File: rtl/fcmp_sync2.sv
module fcmp_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      q  <= 1'b0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/fcmp_regs.sv
module fcmp_regs
  import fcmp_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          set_err,
  input  logic          set_done,
  output logic          enable,
  output logic          single,
  output logic          stat_err,
  output logic          stat_done,
  output logic [CW-1:0] seed_ref,
  output logic [CW-1:0] seed_win,
  output logic [CW-1:0] seed_tst,
  output logic [3:0]    src_sel
);
  logic [15:0] ctrl;
  logic        unused_hi;
  assign unused_hi = ^wdata[DW-1:16];

  assign enable = key_on(ctrl[3:0]);
  assign single = key_on(ctrl[11:8]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      stat_err  <= 1'b0;
      stat_done <= 1'b0;
      seed_ref  <= '0;
      seed_win  <= '0;
      seed_tst  <= '0;
      src_sel   <= '0;
    end else begin
      if (we && addr == AW'(A_CTRL)) ctrl     <= wdata[15:0];
      if (we && addr == AW'(A_SREF)) seed_ref <= wdata[CW-1:0];
      if (we && addr == AW'(A_SWIN)) seed_win <= wdata[CW-1:0];
      if (we && addr == AW'(A_STST)) seed_tst <= wdata[CW-1:0];
      if (we && addr == AW'(A_SRC) && key_on(wdata[15:12])) src_sel <= wdata[3:0];
      // hardware set wins over a same-cycle software clear
      stat_err  <= set_err  | (stat_err  & ~(we && addr == AW'(A_STAT) && wdata[0]));
      stat_done <= set_done | (stat_done & ~(we && addr == AW'(A_STAT) && wdata[1]));
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(A_CTRL): rdata[15:0]   = ctrl;
      AW'(A_STAT): rdata[1:0]    = {stat_done, stat_err};
      AW'(A_SREF): rdata[CW-1:0] = seed_ref;
      AW'(A_SWIN): rdata[CW-1:0] = seed_win;
      AW'(A_STST): rdata[CW-1:0] = seed_tst;
      AW'(A_SRC):  rdata[3:0]    = src_sel;
      default:     rdata         = '0;
    endcase
  end
endmodule

// File: rtl/fcmp_tst_cnt.sv
module fcmp_tst_cnt #(
  parameter int CW = 16
) (
  input  logic          tst_clk,
  input  logic          tst_rst_n,
  input  logic          arm_async,
  input  logic [CW-1:0] seed,
  output logic          expired
);
  logic          arm_s, arm_d;
  logic [CW-1:0] cnt;

  fcmp_sync2 u_arm_sync (
    .clk(tst_clk), .rst_n(tst_rst_n), .d(arm_async), .q(arm_s)
  );

  // seed is quasi-static: written only while the block is disabled
  always_ff @(posedge tst_clk or negedge tst_rst_n) begin
    if (!tst_rst_n) begin
      arm_d   <= 1'b0;
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      arm_d <= arm_s;
      if (!arm_s) begin
        expired <= 1'b0;
      end else if (!arm_d) begin
        cnt     <= seed;
        expired <= 1'b0;
      end else if (!expired) begin
        if (cnt == '0) expired <= 1'b1;
        else           cnt     <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/fcmp_ref_ctl.sv
module fcmp_ref_ctl
  import fcmp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          single,
  input  logic [CW-1:0] seed_ref,
  input  logic [CW-1:0] seed_win,
  input  logic          tst_exp,
  output logic          arm,
  output logic          win_open,
  output logic          busy,
  output logic          exp_pulse,
  output logic          set_err,
  output logic          set_done
);
  meas_state_t   st;
  logic [CW-1:0] rcnt, wcnt;
  logic          exp_d;

  function automatic logic [CW-1:0] step_down(input logic [CW-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  assign exp_pulse = tst_exp & ~exp_d;
  assign arm       = (st == MS_REF) || (st == MS_WIN);
  assign win_open  = (st == MS_WIN);
  assign busy      = arm || (st == MS_RELOAD);
  assign set_err   = enable && (((st == MS_REF) && exp_pulse) ||
                                ((st == MS_WIN) && !exp_pulse && wcnt == '0));
  assign set_done  = enable && (st == MS_WIN) && exp_pulse && single;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= MS_IDLE;
      rcnt  <= '0;
      wcnt  <= '0;
      exp_d <= 1'b0;
    end else begin
      exp_d <= tst_exp;
      case (st)
        MS_IDLE, MS_RELOAD: if ((st == MS_RELOAD || enable) && !tst_exp) begin
          rcnt <= seed_ref;
          wcnt <= seed_win;
          st   <= MS_REF;
        end
        MS_REF: begin
          if (exp_pulse)         st   <= MS_HALT;
          else if (rcnt == '0)   st   <= MS_WIN;
          else                   rcnt <= step_down(rcnt);
        end
        MS_WIN: begin
          if (exp_pulse)         st   <= single ? MS_HALT : MS_RELOAD;
          else if (wcnt == '0)   st   <= MS_HALT;
          else                   wcnt <= step_down(wcnt);
        end
        default: st <= MS_HALT;
      endcase
      if (!enable) st <= MS_IDLE;
    end
  end
endmodule

// File: rtl/fcmp_top.sv
module fcmp_top
  import fcmp_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3,
  parameter int CW = 16
) (
  input  logic          ref_clk,
  input  logic          ref_rst_n,
  input  logic          tst_clk,
  input  logic          tst_rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [3:0]    tst_src_sel
);
  logic          enable, single, stat_err, stat_done;
  logic [CW-1:0] seed_ref, seed_win, seed_tst;
  logic          arm, win_open, busy, exp_pulse, set_err, set_done;
  logic          tst_expired, tst_exp_ref;

  fcmp_regs #(.DW(DW), .AW(AW), .CW(CW)) u_regs (
    .clk(ref_clk), .rst_n(ref_rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .set_err(set_err), .set_done(set_done),
    .enable(enable), .single(single), .stat_err(stat_err), .stat_done(stat_done),
    .seed_ref(seed_ref), .seed_win(seed_win), .seed_tst(seed_tst),
    .src_sel(tst_src_sel)
  );

  fcmp_ref_ctl #(.CW(CW)) u_ctl (
    .clk(ref_clk), .rst_n(ref_rst_n), .enable(enable), .single(single),
    .seed_ref(seed_ref), .seed_win(seed_win), .tst_exp(tst_exp_ref),
    .arm(arm), .win_open(win_open), .busy(busy), .exp_pulse(exp_pulse),
    .set_err(set_err), .set_done(set_done)
  );

  fcmp_tst_cnt #(.CW(CW)) u_tst (
    .tst_clk(tst_clk), .tst_rst_n(tst_rst_n), .arm_async(arm),
    .seed(seed_tst), .expired(tst_expired)
  );

  fcmp_sync2 u_exp_sync (
    .clk(ref_clk), .rst_n(ref_rst_n), .d(tst_expired), .q(tst_exp_ref)
  );
endmodule

// File: rtl/fcmp_checker.sv
module fcmp_checker #(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input logic          ref_clk,
  input logic          ref_rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [3:0]    tst_src_sel,
  input logic          enable,
  input logic          single,
  input logic          arm,
  input logic          win_open,
  input logic          exp_pulse,
  input logic          set_err,
  input logic          set_done,
  input logic          stat_err
);
  // R3 R5: done and error never raised together
  a_r5_err_done_exclusive: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !(set_err && set_done));
  // R3: done only comes from an expiry inside the window
  a_r3_done_in_window: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    set_done |-> (win_open && exp_pulse));
  // R4: expiry while armed but before the window is an error
  a_r4_early_is_err: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (enable && arm && !win_open && exp_pulse) |-> set_err);
  // R10: continuous mode never reports done
  a_r10_cont_no_done: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    set_done |-> single);
  // R2 R11: disabled block drops the arm on the next cycle
  a_r11_disable_disarms: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !enable |=> !arm);
  // R9: select holds unless a keyed write arrives
  a_r9_sel_guarded: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !(reg_we && reg_addr == AW'(5) && reg_wdata[15:12] == 4'hA) |=> $stable(tst_src_sel));
  // R6: write-one clears error unless hardware sets it in the same cycle
  a_r6_w1c_err: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (reg_we && reg_addr == AW'(1) && reg_wdata[0] && !set_err) |=> !stat_err);
endmodule

bind fcmp_top fcmp_checker #(.DW(DW), .AW(AW)) u_chk (
  .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tst_src_sel(tst_src_sel), .enable(enable), .single(single),
  .arm(arm), .win_open(win_open), .exp_pulse(exp_pulse), .set_err(set_err),
  .set_done(set_done), .stat_err(stat_err)
);

// File: tb/tb_fcmp_top.sv
`timescale 1ns/1ps
module tb_fcmp_top;
  logic        ref_clk = 1'b0, tst_clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  tst_src_sel;
  realtime     tst_half = 3.0;
  int          n_chk = 0, n_err = 0;

  typedef struct { string req; logic [1:0] val; } exp_t;
  exp_t sbq[$];

  fcmp_top dut (
    .ref_clk(ref_clk), .ref_rst_n(rst_n), .tst_clk(tst_clk), .tst_rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tst_src_sel(tst_src_sel)
  );

  always #2.5 ref_clk = ~ref_clk;
  initial forever #(tst_half) tst_clk = ~tst_clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // control word: done-irq | mode | err-irq | enable
  function automatic logic [31:0] ctl(input logic [3:0] en, input logic [3:0] mode);
    return {16'h0, 4'h5, mode, 4'h5, en};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge ref_clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge ref_clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge ref_clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  // monitor: pops an expected outcome when status leaves zero
  initial forever begin
    @(posedge ref_clk);
    #1;
    if (sbq.size() > 0 && !reg_we && reg_addr == 3'd1 && reg_rdata[1:0] != 2'b00) begin
      exp_t e;
      e = sbq.pop_front();
      chk(e.req, reg_rdata, {30'h0, e.val});
    end
  end

  task automatic wait_sb(input string req);
    int g = 0;
    while (sbq.size() != 0 && g < 4000) begin @(negedge ref_clk); g++; end
    if (sbq.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL %s: actual no result expected outcome", req);
      sbq.delete();
    end
  endtask

  // driver: configure, push expected outcome, enable, watch
  task automatic measure(input string req, input int s0, input int win, input int s1,
                         input realtime half, input logic [3:0] mode, input logic [1:0] ev);
    logic [31:0] v;
    tst_half = half;
    wr(0, ctl(4'h5, mode));
    wr(1, 32'h3);
    wr(2, s0); wr(3, win); wr(4, s1);
    sbq.push_back('{req, ev});
    wr(0, ctl(4'hA, mode));
    @(negedge ref_clk); reg_addr = 3'd1;
    idle(10);
    chk("R7 busy status", reg_rdata, 32'h0);
    wait_sb(req);
    idle(200);
    rd(1, v);
    chk({req, " held"}, v, {30'h0, ev});
  endtask

  initial begin
    logic [31:0] v;
    idle(4);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 32'h0);
    rd(1, v); chk("R1 stat", v, 32'h0);
    rd(5, v); chk("R1 sel", v, 32'h0);
    chk("R1 sel port", {28'h0, tst_src_sel}, 32'h0);
    // R8 seed readback
    wr(2, 32'h1234); wr(3, 32'h0055); wr(4, 32'hBEEF);
    rd(2, v); chk("R8 ref seed", v, 32'h1234);
    rd(3, v); chk("R8 win seed", v, 32'h0055);
    rd(4, v); chk("R8 tst seed", v, 32'hBEEF);
    // R9 keyed select
    wr(5, 32'h0000_A003); idle(1);
    chk("R9 keyed", {28'h0, tst_src_sel}, 32'h3);
    wr(5, 32'h0000_5007); idle(1);
    chk("R9 off key", {28'h0, tst_src_sel}, 32'h3);
    wr(5, 32'h0000_0009); idle(1);
    chk("R9 bad key", {28'h0, tst_src_sel}, 32'h3);
    // R3 pass in single-shot, two patterns
    measure("R3 pass a", 100, 40, 100, 3.0, 4'hA, 2'b10);
    measure("R3 pass b", 100, 40, 50, 6.0, 4'hA, 2'b10);
    // R4 test clock too fast
    measure("R4 early", 100, 40, 100, 2.0, 4'hA, 2'b01);
    // R5 test clock too slow
    measure("R5 late", 100, 40, 100, 5.0, 4'hA, 2'b01);
    // R2 enable codes other than 0xA stay idle (config would error if run)
    wr(0, ctl(4'h5, 4'hA)); wr(1, 32'h3);
    tst_half = 2.0;
    wr(0, ctl(4'h3, 4'hA)); idle(400);
    rd(1, v); chk("R2 code 3 idle", v, 32'h0);
    wr(0, ctl(4'h5, 4'hA)); idle(400);
    rd(1, v); chk("R2 code 5 idle", v, 32'h0);
    // R11 abort mid-run
    tst_half = 3.0;
    wr(0, ctl(4'hA, 4'hA)); idle(50);
    wr(0, ctl(4'h5, 4'hA)); idle(400);
    rd(1, v); chk("R11 abort", v, 32'h0);
    // R6 partial clears: done then error without clearing
    measure("R6 setup done", 100, 40, 100, 3.0, 4'hA, 2'b10);
    tst_half = 2.0;
    wr(0, ctl(4'h5, 4'hA)); wr(0, ctl(4'hA, 4'hA)); idle(400);
    rd(1, v); chk("R6 both set", v, 32'h3);
    wr(1, 32'h1); rd(1, v); chk("R6 clear err", v, 32'h2);
    wr(1, 32'h2); rd(1, v); chk("R6 clear done", v, 32'h0);
    // R10 continuous: passes repeat silently, then a slow clock fails
    wr(0, ctl(4'h5, 4'h5)); wr(1, 32'h3);
    tst_half = 3.0;
    wr(2, 100); wr(3, 40); wr(4, 100);
    wr(0, ctl(4'hA, 4'h5));
    idle(1500);
    rd(1, v); chk("R10 repeat quiet", v, 32'h0);
    sbq.push_back('{"R10 fail stops", 2'b01});
    tst_half = 5.0;
    @(negedge ref_clk); reg_addr = 3'd1;
    wait_sb("R10 fail stops");
    idle(400);
    rd(1, v); chk("R10 stays stopped", v, 32'h1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge ref_clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule